// File: doc/BRIEF.md
# Spectral Occupancy Histogram Accumulator

The block builds a two-dimensional occupancy map from a stream of quantized power codes, one code per FFT frequency point. Every accepted sample names a frequency point and a power level. The block adds one to the count stored for that (point, level) pair. Over a frame of several FFT sweeps, each count records how often that point sat at that level. The result is a waterfall-style picture of the spectrum rather than a plain value histogram. One instance serves one receive channel, and each instance holds its own storage.

Storage is split into two banks. One bank collects the current frame. The other bank is streamed out and zeroed at the same time, so a new frame can start collecting on the very next cycle. A credit register set by a request pulse decides how many completed frames are sent out. Frames completed without credit are still zeroed but produce no output. A clear pulse, and reset, start a sweep that zeroes both banks.

Top module: `occ_hist_top`

## Requirements
- R1: After reset, or on a cycle with `spec_clr` high, the block runs a clear sweep of NPTS*NLVL cycles. During the sweep `in_valid` is ignored and `out_valid` stays low. When the sweep ends all counts are zero and the frame sample count restarts at zero.
- R2: An accepted sample adds one to the bin at linear index `in_point*NLVL + in_level`.
- R3: A frame ends on the NPTS*ITERS-th accepted sample. With credit available, its NPTS*NLVL counts are then streamed out as one contiguous burst, starting two clock edges after the edge that accepted the last sample.
- R4: Readout runs in bin-index order: all NLVL levels of point 0 (level 0 first), then point 1, and so on. `out_last` is high on exactly the final beat, at index NPTS*NLVL-1.
- R5: Each frame starts from zero. Counts from an earlier frame never show up in a later one.
- R6: Samples that hit the same bin on consecutive cycles are each counted. No increment is lost.
- R7: A count stops at 2^CNT_W-1. Further hits leave it at that value.
- R8: `frm_req` loads the credit from `frm_count`. Each completed frame is sent out only if the credit is non-zero, and sending it uses one credit. A frame completed at zero credit produces no `out_valid` beat.
- R9: Samples are accepted on every cycle outside the clear sweep, including while the previous frame is being read out.
- R10: A `spec_clr` pulse during a readout ends the burst. `out_valid` is low from the next cycle, the rest of that frame never appears, and the credit drops to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spec_clr | input | 1 | Clear pulse: restarts the zeroing sweep and drops credit |
| in_valid | input | 1 | Power-code sample present |
| in_point | input | $clog2(NPTS) | FFT frequency point of the sample |
| in_level | input | $clog2(NLVL) | Quantized power level of the sample |
| frm_req | input | 1 | Load the frame credit |
| frm_count | input | FRM_W | Number of frames to send out |
| out_valid | output | 1 | Count beat present |
| out_count | output | CNT_W | Bin count |
| out_last | output | 1 | Final bin of the frame |

## Verification
The bench uses NPTS=8, NLVL=8, ITERS=16 and CNT_W=5. That gives a 64-bin map, a 128-sample frame and a 64-beat readout. Because readout is shorter than a frame, back-to-back frames with no idle cycle are legal, and bank alternation is exercised at full rate. A frame that hits one bin with all 128 samples drives that count past 31, so saturation and same-bin forwarding are reached every cycle. The small bin count also lets the bench time the clear sweep exactly, feeding it samples that must be ignored.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic {
    PH_CLEAR = 1'b0,
    PH_RUN   = 1'b1
  } occ_phase_e;
endpackage

// File: rtl/occ_bank_ram.sv
module occ_bank_ram #(
  parameter int AW = 6,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-before-write on a shared address
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/occ_accum.sv
module occ_accum #(
  parameter int AW = 6,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          take,
  input  logic [AW-1:0] in_addr,
  input  logic          in_bank,
  input  logic [CW-1:0] rd_data,
  output logic          s1_bank,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bank,
  output logic [CW-1:0] wr_data
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          s1_vld_q, s1_vld_n;
  logic [AW-1:0] s1_addr_q, s1_addr_n;
  logic          s1_bank_q, s1_bank_n;
  logic          lw_vld_q, lw_vld_n;
  logic [AW-1:0] lw_addr_q, lw_addr_n;
  logic          lw_bank_q, lw_bank_n;
  logic [CW-1:0] lw_data_q, lw_data_n;
  logic          fwd_hit;
  logic [CW-1:0] base;

  always_comb begin
    // last cycle's write is not yet visible in the read data
    fwd_hit = lw_vld_q && (lw_addr_q == s1_addr_q) && (lw_bank_q == s1_bank_q);
    base    = fwd_hit ? lw_data_q : rd_data;
    wr_data = (base == CMAX) ? base : base + 1'b1;
    wr_en   = s1_vld_q;
    wr_addr = s1_addr_q;
    wr_bank = s1_bank_q;
    s1_bank = s1_bank_q;

    s1_vld_n  = take && !flush;
    s1_addr_n = s1_addr_q;
    s1_bank_n = s1_bank_q;
    if (take) begin
      s1_addr_n = in_addr;
      s1_bank_n = in_bank;
    end
    lw_vld_n  = s1_vld_q && !flush;
    lw_addr_n = s1_addr_q;
    lw_bank_n = s1_bank_q;
    lw_data_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_addr_q <= '0;
      s1_bank_q <= 1'b0;
      lw_vld_q  <= 1'b0;
      lw_addr_q <= '0;
      lw_bank_q <= 1'b0;
      lw_data_q <= '0;
    end else begin
      s1_vld_q  <= s1_vld_n;
      s1_addr_q <= s1_addr_n;
      s1_bank_q <= s1_bank_n;
      lw_vld_q  <= lw_vld_n;
      lw_addr_q <= lw_addr_n;
      lw_bank_q <= lw_bank_n;
      lw_data_q <= lw_data_n;
    end
  end
endmodule

// File: rtl/occ_seq.sv
module occ_seq
  import occ_pkg::*;
#(
  parameter int NBINS = 64,
  parameter int FRAME = 128,
  parameter int FW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spec_clr,
  input  logic                     in_valid,
  input  logic                     frm_req,
  input  logic [FW-1:0]            frm_count,
  output logic                     take,
  output logic                     acc_bank,
  output logic                     clr_busy,
  output logic [$clog2(NBINS)-1:0] clr_addr,
  output logic                     ro_on,
  output logic [$clog2(NBINS)-1:0] ro_addr,
  output logic                     ro_bank,
  output logic                     out_valid,
  output logic                     out_last,
  output logic                     out_bank
);
  localparam int AW = $clog2(NBINS);
  localparam int SW = $clog2(FRAME);
  localparam logic [AW-1:0] ALAST = AW'(NBINS - 1);
  localparam logic [SW-1:0] SLAST = SW'(FRAME - 1);

  occ_phase_e    phase_q, phase_n;
  logic [AW-1:0] clr_addr_q, clr_addr_n;
  logic [SW-1:0] smp_q, smp_n;
  logic          acc_bank_q, acc_bank_n;
  logic          pend_q, pend_n;
  logic          pend_bank_q, pend_bank_n;
  logic          ro_on_q, ro_on_n;
  logic [AW-1:0] ro_addr_q, ro_addr_n;
  logic          ro_bank_q, ro_bank_n;
  logic          ro_emit_q, ro_emit_n;
  logic [FW-1:0] credit_q, credit_n;
  logic          ov_q, ov_n;
  logic          ol_q, ol_n;
  logic          ob_q, ob_n;
  logic          wrap;

  always_comb begin
    phase_n     = phase_q;
    clr_addr_n  = clr_addr_q;
    smp_n       = smp_q;
    acc_bank_n  = acc_bank_q;
    ro_on_n     = ro_on_q;
    ro_addr_n   = ro_addr_q;
    ro_bank_n   = ro_bank_q;
    ro_emit_n   = ro_emit_q;
    credit_n    = credit_q;

    take = in_valid && (phase_q == PH_RUN) && !spec_clr;
    wrap = take && (smp_q == SLAST);

    if (phase_q == PH_CLEAR) begin
      clr_addr_n = clr_addr_q + 1'b1;
      if (clr_addr_q == ALAST) phase_n = PH_RUN;
    end

    if (take) begin
      smp_n = wrap ? '0 : smp_q + 1'b1;
      if (wrap) acc_bank_n = !acc_bank_q;
    end
    // readout waits one cycle so the frame's final write has landed
    pend_n      = wrap;
    pend_bank_n = acc_bank_q;

    ov_n = 1'b0;
    ol_n = 1'b0;
    ob_n = ro_bank_q;
    if (ro_on_q) begin
      ov_n      = ro_emit_q;
      ol_n      = ro_emit_q && (ro_addr_q == ALAST);
      ro_addr_n = ro_addr_q + 1'b1;
      if (ro_addr_q == ALAST) ro_on_n = 1'b0;
    end
    if (pend_q) begin
      ro_on_n   = 1'b1;
      ro_addr_n = '0;
      ro_bank_n = pend_bank_q;
      ro_emit_n = (credit_q != '0);
      if (credit_q != '0) credit_n = credit_q - 1'b1;
    end
    if (frm_req) credit_n = frm_count;

    if (spec_clr) begin
      phase_n    = PH_CLEAR;
      clr_addr_n = '0;
      smp_n      = '0;
      acc_bank_n = 1'b0;
      pend_n     = 1'b0;
      ro_on_n    = 1'b0;
      credit_n   = '0;
      ov_n       = 1'b0;
      ol_n       = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_CLEAR;
      clr_addr_q  <= '0;
      smp_q       <= '0;
      acc_bank_q  <= 1'b0;
      pend_q      <= 1'b0;
      pend_bank_q <= 1'b0;
      ro_on_q     <= 1'b0;
      ro_addr_q   <= '0;
      ro_bank_q   <= 1'b0;
      ro_emit_q   <= 1'b0;
      credit_q    <= '0;
      ov_q        <= 1'b0;
      ol_q        <= 1'b0;
      ob_q        <= 1'b0;
    end else begin
      phase_q     <= phase_n;
      clr_addr_q  <= clr_addr_n;
      smp_q       <= smp_n;
      acc_bank_q  <= acc_bank_n;
      pend_q      <= pend_n;
      pend_bank_q <= pend_bank_n;
      ro_on_q     <= ro_on_n;
      ro_addr_q   <= ro_addr_n;
      ro_bank_q   <= ro_bank_n;
      ro_emit_q   <= ro_emit_n;
      credit_q    <= credit_n;
      ov_q        <= ov_n;
      ol_q        <= ol_n;
      ob_q        <= ob_n;
    end
  end

  assign acc_bank  = acc_bank_q;
  assign clr_busy  = (phase_q == PH_CLEAR);
  assign clr_addr  = clr_addr_q;
  assign ro_on     = ro_on_q;
  assign ro_addr   = ro_addr_q;
  assign ro_bank   = ro_bank_q;
  assign out_valid = ov_q;
  assign out_last  = ol_q;
  assign out_bank  = ob_q;
endmodule

// File: rtl/occ_hist_top.sv
module occ_hist_top #(
  parameter int NPTS  = 8,
  parameter int NLVL  = 8,
  parameter int ITERS = 16,
  parameter int CNT_W = 5,
  parameter int FRM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spec_clr,
  input  logic                    in_valid,
  input  logic [$clog2(NPTS)-1:0] in_point,
  input  logic [$clog2(NLVL)-1:0] in_level,
  input  logic                    frm_req,
  input  logic [FRM_W-1:0]        frm_count,
  output logic                    out_valid,
  output logic [CNT_W-1:0]        out_count,
  output logic                    out_last
);
  localparam int NBINS = NPTS * NLVL;
  localparam int FRAME = NPTS * ITERS;
  localparam int AW    = $clog2(NBINS);

  logic [1:0]       rst_pipe;
  logic             rst_int;
  logic [AW-1:0]    in_addr;
  logic             take, acc_bank, clr_busy, ro_on, ro_bank, out_bank;
  logic [AW-1:0]    clr_addr, ro_addr;
  logic             acc_s1_bank, acc_we, acc_wbank;
  logic [AW-1:0]    acc_waddr;
  logic [CNT_W-1:0] acc_wdata, acc_rdata;
  logic [AW-1:0]    bk_raddr [2];
  logic [CNT_W-1:0] bk_rdata [2];
  logic             bk_we    [2];
  logic [AW-1:0]    bk_waddr [2];
  logic [CNT_W-1:0] bk_wdata [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  // point-major linear index: levels of one point are adjacent
  assign in_addr = {in_point, in_level};

  occ_seq #(.NBINS(NBINS), .FRAME(FRAME), .FW(FRM_W)) u_seq (
    .clk(clk), .rst_n(rst_int), .spec_clr(spec_clr), .in_valid(in_valid),
    .frm_req(frm_req), .frm_count(frm_count), .take(take),
    .acc_bank(acc_bank), .clr_busy(clr_busy), .clr_addr(clr_addr),
    .ro_on(ro_on), .ro_addr(ro_addr), .ro_bank(ro_bank),
    .out_valid(out_valid), .out_last(out_last), .out_bank(out_bank)
  );

  occ_accum #(.AW(AW), .CW(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_int), .flush(spec_clr), .take(take),
    .in_addr(in_addr), .in_bank(acc_bank), .rd_data(acc_rdata),
    .s1_bank(acc_s1_bank), .wr_en(acc_we), .wr_addr(acc_waddr),
    .wr_bank(acc_wbank), .wr_data(acc_wdata)
  );

  assign acc_rdata = bk_rdata[acc_s1_bank];
  assign out_count = bk_rdata[out_bank];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic ro_here;
    assign ro_here     = ro_on && (ro_bank == 1'(b));
    assign bk_raddr[b] = ro_here ? ro_addr : in_addr;
    assign bk_we[b]    = clr_busy || ro_here || (acc_we && (acc_wbank == 1'(b)));
    assign bk_waddr[b] = clr_busy ? clr_addr : (ro_here ? ro_addr : acc_waddr);
    assign bk_wdata[b] = (clr_busy || ro_here) ? '0 : acc_wdata;

    occ_bank_ram #(.AW(AW), .DW(CNT_W)) u_ram (
      .clk(clk), .rd_addr(bk_raddr[b]), .rd_data(bk_rdata[b]),
      .wr_en(bk_we[b]), .wr_addr(bk_waddr[b]), .wr_data(bk_wdata[b])
    );
  end
endmodule

// File: rtl/occ_hist_check.sv
module occ_hist_check #(
  parameter int NBINS = 64,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spec_clr,
  input logic          out_valid,
  input logic          out_last,
  input logic          clr_busy,
  input logic          acc_we,
  input logic [CW-1:0] acc_wdata
);
  localparam int AW = $clog2(NBINS);
  localparam logic [AW-1:0] LAST = AW'(NBINS - 1);

  logic [AW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         beat_q <= '0;
    else if (spec_clr)  beat_q <= '0;
    else if (out_valid) beat_q <= out_last ? '0 : beat_q + 1'b1;
  end

  a_r1_quiet_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !out_valid);

  a_r4_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r3_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !spec_clr) |=> out_valid);

  a_r4_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (beat_q == LAST)));

  a_r6_write_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (acc_wdata != '0));
endmodule

bind occ_hist_top occ_hist_check #(.NBINS(NBINS), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_clr(spec_clr), .out_valid(out_valid),
  .out_last(out_last), .clr_busy(clr_busy), .acc_we(acc_we), .acc_wdata(acc_wdata)
);

// File: tb/occ_hist_top_test.sv
module occ_hist_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPTS  = 8;
  localparam int NLVL  = 8;
  localparam int ITERS = 16;
  localparam int CNT_W = 5;
  localparam int FRM_W = 8;
  localparam int PW    = $clog2(NPTS);
  localparam int LW    = $clog2(NLVL);
  localparam int NBINS = NPTS * NLVL;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n, spec_clr, in_valid, frm_req;
  logic [PW-1:0]    in_point;
  logic [LW-1:0]    in_level;
  logic [FRM_W-1:0] frm_count;
  logic             out_valid, out_last;
  logic [CNT_W-1:0] out_count;

  int    n_chk = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  int    model[NBINS];
  int    credit = 0;
  int    frames_seen = 0;
  int    idx = 0, fbad = 0, f_at = 0, f_act = 0, f_exp = 0, lastbad = 0;
  bit    done = 1'b0;

  occ_hist_top #(.NPTS(NPTS), .NLVL(NLVL), .ITERS(ITERS), .CNT_W(CNT_W),
                 .FRM_W(FRM_W)) uut (
    .clk(clk), .rst_n(rst_n), .spec_clr(spec_clr), .in_valid(in_valid),
    .in_point(in_point), .in_level(in_level), .frm_req(frm_req),
    .frm_count(frm_count), .out_valid(out_valid), .out_count(out_count),
    .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitor: compares each beat with the bench model
  always @(negedge clk) begin
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "beat with no expected frame", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(out_count) != e && fbad == 0) begin
          fbad = 1; f_at = idx; f_act = int'(out_count); f_exp = e;
        end
        if (out_last != (idx == NBINS - 1)) lastbad = 1;
        idx++;
        if (out_last || idx == NBINS) begin
          string t;
          t = (tag_q.size() != 0) ? tag_q.pop_front() : "R3";
          check(fbad == 0, t, $sformatf("bin %0d count", f_at), f_act, f_exp);
          check(lastbad == 0 && idx == NBINS, "R4", "last flag position", idx, NBINS);
          frames_seen++;
          idx = 0; fbad = 0; lastbad = 0;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic request(input int n);
    in_valid = 1'b0; frm_req = 1'b1; frm_count = FRM_W'(n);
    tick();
    frm_req = 1'b0;
    credit = n;
  endtask

  // kinds: 0 staircase, 1 random levels, 2 random with gaps,
  //        3 one bin every sample, 4 random bins with repeats
  task automatic run_frame(input int kind, input string tag);
    int pt, lvl;
    pt = 0; lvl = 0;
    for (int i = 0; i < NBINS; i++) model[i] = 0;
    for (int s = 0; s < NPTS * ITERS; s++) begin
      int it, p;
      it = s / NPTS; p = s % NPTS;
      case (kind)
        0: begin pt = p; lvl = (p + it / 4) % NLVL; end
        1, 2: begin pt = p; lvl = $urandom_range(NLVL - 1); end
        3: begin pt = 0; lvl = NLVL - 1; end
        default: if (s == 0 || $urandom_range(1) == 0) begin
          pt = $urandom_range(NPTS - 1); lvl = $urandom_range(NLVL - 1);
        end
      endcase
      if (kind == 2) begin
        int g;
        g = $urandom_range(2);
        for (int k = 0; k < g; k++) begin in_valid = 1'b0; tick(); end
      end
      in_valid = 1'b1; in_point = PW'(pt); in_level = LW'(lvl);
      if (model[pt * NLVL + lvl] < CMAX) model[pt * NLVL + lvl]++;
      tick();
    end
    in_valid = 1'b0;
    if (credit > 0) begin
      for (int i = 0; i < NBINS; i++) exp_q.push_back(model[i]);
      tag_q.push_back(tag);
      credit--;
    end
  endtask

  task automatic drain();
    repeat (NBINS + 8) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(1'b0, "R3", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h0c5e_11a7));
    rst_n = 1'b0; spec_clr = 1'b0; in_valid = 1'b0; frm_req = 1'b0;
    in_point = '0; in_level = '0; frm_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_last == 1'b0, "R1", "out_last in reset", int'(out_last), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (NBINS + 8) tick();

    // directed frames back to back: bank alternation at full rate
    request(7);
    run_frame(0, "R2");
    run_frame(1, "R9");
    run_frame(3, "R7");
    run_frame(4, "R6");
    run_frame(2, "R5");
    drain();
    check(frames_seen == 5, "R3", "frames delivered", frames_seen, 5);
    check(exp_q.size() == 0, "R3", "undelivered beats", exp_q.size(), 0);

    // random frames, then credit exhaustion
    request(3);
    for (int f = 0; f < 3; f++) run_frame(1 + $urandom_range(1), "R2");
    drain();
    base = frames_seen;
    request(1);
    run_frame(1, "R8");
    run_frame(4, "R8");
    drain();
    check(frames_seen - base == 1, "R8", "frames sent with one credit",
          frames_seen - base, 1);

    // clear pulse with junk samples during the sweep
    in_valid = 1'b1; in_point = '1; in_level = '1; spec_clr = 1'b1;
    tick();
    spec_clr = 1'b0;
    for (int k = 0; k < NBINS; k++) begin
      in_point = PW'($urandom_range(NPTS - 1));
      in_level = LW'($urandom_range(NLVL - 1));
      tick();
    end
    in_valid = 1'b0;
    request(1);
    run_frame(1, "R1");
    drain();

    // clear pulse in the middle of a readout
    base = frames_seen;
    request(1);
    run_frame(1, "R10");
    repeat (20) tick();
    spec_clr = 1'b1;
    tick();
    spec_clr = 1'b0;
    exp_q.delete(); tag_q.delete(); idx = 0; fbad = 0; lastbad = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after clear", int'(out_valid), 0);
    @(posedge clk); #1;
    repeat (NBINS + 8) tick();
    check(frames_seen == base, "R10", "aborted frame completed", frames_seen, base);

    request(1);
    run_frame(0, "R5");
    drain();
    check(frames_seen == base + 1, "R5", "frame after clear", frames_seen, base + 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule